// File: doc/BRIEF.md
# Vector Unsigned Rounding Shift-Right Unit

This block executes one vector instruction class: an unsigned rounding shift right on a register operand of up to 128 bits. It can optionally add each rounded lane into the matching lane of the destination register. The caller presents a 32-bit instruction word, the source vector, the current destination value and a valid strobe. One clock later the block returns the new destination value with a single-cycle write-enable. When the encoding cannot be executed, it raises a one-cycle fault flag and does not write.

A single packed 7-bit immediate carries both the lane width and the shift count. The highest set bit of its upper four bits selects a lane width of 8, 16, 32 or 64 bits. The shift count is twice the lane width minus the full 7-bit value, so it always lies between 1 and the lane width. The instruction's size bit selects a 64-bit or a 128-bit operation.

A small state machine controls the output. It has three named states:
- **ST_IDLE**: no output pending.
- **ST_WRITE**: result valid, write-enable high.
- **ST_FAULT**: one error flag high.

Every clock, each state takes one of three named transitions:
- **accept-write**: a valid, executable word leads to ST_WRITE.
- **accept-fault**: a valid word with a bad immediate leads to ST_FAULT.
- **drop**: no valid word, or a word outside this class, leads to ST_IDLE.

Because every state takes the same three transitions, back-to-back operations run at one per clock.

Top module: `rsra_unit`

## Requirements
- R1: A word belongs to this class only when bit 31 is 0, bits 29:23 are 1011110, and bits 15:10 equal 001001 (plain form) or 001101 (accumulate form). Any other valid word produces no write and no flag.
- R2: The lane width is 8 shifted left by the index of the highest set bit of bits 22:19. The shift count is twice the lane width minus the value of bits 22:16.
- R3: Each lane result is the lane shifted right logically by the shift count, plus the lane bit at position (shift count - 1). A shift equal to the lane width therefore gives the lane's top bit.
- R4: In the accumulate form, each rounded lane is added to the matching destination lane, wrapping modulo 2^lane width. In the plain form, the destination input has no effect.
- R5: Bit 30 set selects a 128-bit operation. Bit 30 clear selects 64 bits, and the upper 64 bits of the written value are zero.
- R6: A class word with bits 22:19 all zero raises dec_err for one cycle and does not write. At most one of wr_en, dec_err and rsv_err is high in any cycle.
- R7: A class word with bit 30 clear and bit 22 set raises rsv_err for one cycle and does not write.
- R8: All outputs appear in the cycle after the clock edge that samples in_valid, and last one cycle. Without in_valid, wr_en, dec_err and rsv_err stay low in the following cycle.
- R9: After reset, wr_en, dec_err and rsv_err are low and wr_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector operand |
| dst_vec | input | 128 | Current destination value (accumulate input) |
| wr_en | output | 1 | One-cycle destination write strobe |
| wr_data | output | 128 | New destination value, meaningful while wr_en is high |
| dec_err | output | 1 | One-cycle flag: all-zero lane-size field |
| rsv_err | output | 1 | One-cycle flag: 64-bit lanes in a 64-bit operation |

## Verification
The bench sweeps every shift count of every lane width in both forms and both sizes. This catches an off-by-one in the shift formula, which would shift every lane one place too far or too little. It drives lanes with only the top bit set at the full-width shift, where a design that drops the rounding bit returns 0 instead of 1. It drives all-ones destination lanes in the accumulate form, where a carry that leaks across a lane boundary corrupts the neighbouring lane. It also checks that narrow operations leave the upper half at zero, and sends all-zero and reserved immediates and foreign opcodes, where a wrong design would write or raise the wrong flag.

// File: rtl/rsra_pkg.sv
package rsra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } rsra_state_e;

    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2,
        LW_64 = 2'd3
    } lane_sel_e;

    localparam int SH_W  = 7;
    localparam int IMM_W = 7;

    typedef struct packed {
        logic             hit;
        logic             acc;
        logic             wide;
        logic             dec_err;
        logic             rsv_err;
        lane_sel_e        lsel;
        logic [SH_W-1:0]  shamt;
    } rsra_dec_t;

    localparam logic [6:0] CLASS_BITS = 7'b1011110;
    localparam logic [5:0] OPC_PLAIN  = 6'b001001;
    localparam logic [5:0] OPC_ACC    = 6'b001101;

endpackage

// File: rtl/rsra_decode.sv
module rsra_decode
    import rsra_pkg::*;
(
    input  logic [31:0] instr_i,
    output rsra_dec_t   dec_o
);

    logic [3:0]       lsz_field;
    logic [IMM_W-1:0] imm_all;
    logic [5:0]       opc;
    logic [7:0]       twice_w;

    always_comb begin
        lsz_field = instr_i[22:19];
        imm_all   = instr_i[22:16];
        opc       = instr_i[15:10];

        dec_o.hit  = (instr_i[31] == 1'b0) && (instr_i[29:23] == CLASS_BITS)
                     && ((opc == OPC_PLAIN) || (opc == OPC_ACC));
        dec_o.acc  = (opc == OPC_ACC);
        dec_o.wide = instr_i[30];

        if (lsz_field[3]) begin
            dec_o.lsel = LW_64;
            twice_w    = 8'd128;
        end else if (lsz_field[2]) begin
            dec_o.lsel = LW_32;
            twice_w    = 8'd64;
        end else if (lsz_field[1]) begin
            dec_o.lsel = LW_16;
            twice_w    = 8'd32;
        end else begin
            dec_o.lsel = LW_8;
            twice_w    = 8'd16;
        end

        dec_o.shamt   = SH_W'(twice_w - {1'b0, imm_all});
        dec_o.dec_err = dec_o.hit && (lsz_field == 4'b0000);
        dec_o.rsv_err = dec_o.hit && !dec_o.dec_err && !instr_i[30] && lsz_field[3];
    end

    always_comb begin
        if (dec_o.hit && !dec_o.dec_err) begin
            AST_SHAMT_IN_RANGE: assert (dec_o.shamt >= SH_W'(1) && dec_o.shamt <= SH_W'(64))
                else $error("shift count out of range"); // R2
        end
    end

endmodule

// File: rtl/rsra_lane.sv
module rsra_lane
    import rsra_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    x_i,
    input  logic [W-1:0]    acc_val_i,
    input  logic [SH_W-1:0] sh_i,
    input  logic            acc_en_i,
    output logic [W-1:0]    res_o
);

    logic [W-1:0] shifted;
    logic [W-1:0] below;
    logic [W-1:0] rounded;
    logic         rnd;

    always_comb begin
        shifted = x_i >> sh_i;
        below   = x_i >> (sh_i - SH_W'(1));
        rnd     = below[0];
        rounded = shifted + W'(rnd);
        res_o   = acc_en_i ? (acc_val_i + rounded) : rounded;
    end

    always_comb begin
        if ((sh_i == SH_W'(W)) && !acc_en_i) begin
            AST_FULL_SHIFT_TOPBIT: assert (res_o == W'(x_i[W-1]))
                else $error("full-width shift lost the rounding bit"); // R3
        end
    end

endmodule

// File: rtl/rsra_vec.sv
module rsra_vec
    import rsra_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] src_i,
    input  logic [VEC_W-1:0] dst_i,
    input  rsra_dec_t        dec_i,
    output logic [VEC_W-1:0] res_o
);

    localparam int N_SIZES = 4;
    localparam int HALF_W  = VEC_W / 2;

    logic [VEC_W-1:0] cand [N_SIZES];
    logic [VEC_W-1:0] picked;

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            rsra_lane #(.W(LW)) u_lane (
                .x_i      (src_i[l*LW +: LW]),
                .acc_val_i(dst_i[l*LW +: LW]),
                .sh_i     (dec_i.shamt),
                .acc_en_i (dec_i.acc),
                .res_o    (cand[g][l*LW +: LW])
            );
        end
    end

    always_comb begin
        unique case (dec_i.lsel)
            LW_8:    picked = cand[0];
            LW_16:   picked = cand[1];
            LW_32:   picked = cand[2];
            LW_64:   picked = cand[3];
            default: picked = '0;
        endcase
        res_o = picked;
        if (!dec_i.wide) begin
            res_o[VEC_W-1:HALF_W] = '0;
        end
    end

endmodule

// File: rtl/rsra_unit.sv
module rsra_unit
    import rsra_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    output logic             wr_en,
    output logic [VEC_W-1:0] wr_data,
    output logic             dec_err,
    output logic             rsv_err
);

    localparam int HALF_W = VEC_W / 2;

    rsra_dec_t        dec;
    logic [VEC_W-1:0] vec_res;
    rsra_state_e      state_q;
    rsra_state_e      state_d;
    logic [VEC_W-1:0] data_q;
    logic             dec_q;
    logic             rsv_q;
    logic             go_write;
    logic             go_fault;

    rsra_decode u_decode (
        .instr_i(instr),
        .dec_o  (dec)
    );

    rsra_vec #(.VEC_W(VEC_W)) u_vec (
        .src_i(src_vec),
        .dst_i(dst_vec),
        .dec_i(dec),
        .res_o(vec_res)
    );

    always_comb begin
        go_fault = in_valid && dec.hit && (dec.dec_err || dec.rsv_err);
        go_write = in_valid && dec.hit && !dec.dec_err && !dec.rsv_err;
    end

    // next-state logic: accept-write, accept-fault or drop from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_FAULT: begin
                if (go_write)      state_d = ST_WRITE;
                else if (go_fault) state_d = ST_FAULT;
                else               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dec_q  <= 1'b0;
            rsv_q  <= 1'b0;
        end else begin
            if (go_write) data_q <= vec_res;
            if (go_fault) begin
                dec_q <= dec.dec_err;
                rsv_q <= dec.rsv_err;
            end
        end
    end

    always_comb begin
        wr_en   = (state_q == ST_WRITE);
        wr_data = data_q;
        dec_err = (state_q == ST_FAULT) && dec_q;
        rsv_err = (state_q == ST_FAULT) && rsv_q;
    end

    AST_WE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid)) else $error("write without valid"); // R8
    AST_QUIET_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(wr_en || dec_err || rsv_err)) else $error("spurious output"); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, dec_err, rsv_err}) <= 1) else $error("outcomes overlap"); // R6
    AST_DECERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> ($past(instr[22:19]) == 4'b0000)) else $error("bad dec_err"); // R6
    AST_RSVERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err |-> (!$past(instr[30]) && $past(instr[22]))) else $error("bad rsv_err"); // R7
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(instr[30])) |-> (wr_data[VEC_W-1:HALF_W] == '0))
        else $error("upper half not cleared"); // R5

endmodule

// File: tb/rsra_unit_bench.sv
`timescale 1ns/1ps
module rsra_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic         wr_en;
    logic [127:0] wr_data;
    logic         dec_err;
    logic         rsv_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    rsra_unit u_rsra_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .instr   (instr),
        .src_vec (src_vec),
        .dst_vec (dst_vec),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dec_err (dec_err),
        .rsv_err (rsv_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit q, input bit acc,
                                       input logic [6:0] imm);
        return {1'b0, q, 7'b1011110, imm, acc ? 6'b001101 : 6'b001001, 5'd3, 5'd7};
    endfunction

    function automatic logic [127:0] ref_calc(input logic [31:0] ins,
                                              input logic [127:0] s,
                                              input logic [127:0] d);
        logic [3:0]  h;
        int          esz, sh, nl;
        logic [63:0] m, x, y, r;
        logic [127:0] o;
        h   = ins[22:19];
        esz = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
        sh  = 2 * esz - int'(ins[22:16]);
        nl  = (ins[30] ? 128 : 64) / esz;
        m   = (esz == 64) ? '1 : ((64'd1 << esz) - 64'd1);
        o   = '0;
        for (int i = 0; i < nl; i++) begin
            x = 64'(s >> (i * esz)) & m;
            y = 64'(d >> (i * esz)) & m;
            r = (x >> sh) + ((x >> (sh - 1)) & 64'd1);
            if (ins[15:10] == 6'b001101) r = r + y;
            r = r & m;
            o = o | (128'(r) << (i * esz));
        end
        return o;
    endfunction

    // kind: 0 none, 1 write, 2 dec_err, 3 rsv_err
    function automatic int kind_of(input logic [31:0] ins);
        bit hit;
        hit = !ins[31] && ins[29:23] == 7'b1011110
              && (ins[15:10] == 6'b001001 || ins[15:10] == 6'b001101);
        if (!hit) return 0;
        if (ins[22:19] == 4'b0000) return 2;
        if (!ins[30] && ins[22]) return 3;
        return 1;
    endfunction

    task automatic run_op(input logic [31:0] ins, input logic [127:0] s,
                          input logic [127:0] d, input string req);
        int k;
        logic [127:0] e;
        k = kind_of(ins);
        e = ref_calc(ins, s, d);
        in_valid = 1'b1; instr = ins; src_vec = s; dst_vec = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk(wr_en == (k == 1), "R8", "wr_en after valid", 128'(wr_en), 128'(k == 1));
        chk(dec_err == (k == 2), "R6", "dec_err", 128'(dec_err), 128'(k == 2));
        chk(rsv_err == (k == 3), "R7", "rsv_err", 128'(rsv_err), 128'(k == 3));
        if (k == 0) chk(!wr_en && !dec_err && !rsv_err, "R1", "foreign word", 128'(wr_en), 0);
        if (k == 1) chk(wr_data == e, req, "result", wr_data, e);
        src_vec = ~s; dst_vec = ~d;
        @(negedge clk);
        chk(!wr_en && !dec_err && !rsv_err, "R8", "single-cycle pulse",
            {125'd0, wr_en, dec_err, rsv_err}, 0);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL R8 watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        repeat (4) @(negedge clk);
        chk(!wr_en && !dec_err && !rsv_err && wr_data == '0, "R9", "reset state",
            wr_data | {125'd0, wr_en, dec_err, rsv_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: every lane width, every shift, both forms, both sizes
        for (int q = 0; q < 2; q++)
            for (int a = 0; a < 2; a++)
                for (int g = 0; g < 4; g++)
                    for (int v = (8 << g); v < (16 << g); v++)
                        run_op(mk(q[0], a[0], 7'(v)), rnd128(), rnd128(),
                               a ? "R4" : "R3");

        // R3: full-width shift with only the top bit set rounds up to 1
        run_op(mk(1'b1, 1'b0, 7'd8), {16{8'h80}}, rnd128(), "R3");
        run_op(mk(1'b1, 1'b0, 7'd64), {2{64'h8000_0000_0000_0000}}, '0, "R3");
        // R4: accumulate wraps inside each lane
        run_op(mk(1'b1, 1'b1, 7'd8), {16{8'h80}}, {16{8'hFF}}, "R4");
        run_op(mk(1'b1, 1'b1, 7'd16), {8{16'h8000}}, {8{16'hFFFF}}, "R4");
        // R5: narrow op with dirty upper source
        run_op(mk(1'b0, 1'b1, 7'd40), '1, '1, "R5");
        // R6 / R7 corner encodings
        run_op(mk(1'b1, 1'b0, 7'd5), rnd128(), rnd128(), "R6");
        run_op(mk(1'b0, 1'b1, 7'd0), rnd128(), rnd128(), "R6");
        run_op(mk(1'b0, 1'b0, 7'd100), rnd128(), rnd128(), "R7");
        // R1: foreign words
        run_op(mk(1'b1, 1'b0, 7'd9) | 32'h8000_0000, rnd128(), rnd128(), "R1");
        run_op((mk(1'b1, 1'b0, 7'd9) & ~32'h0000_FC00) | 32'h0000_0400, rnd128(), rnd128(), "R1");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = mk(1'($urandom), 1'($urandom), 7'($urandom));
            if (($urandom % 8) == 0) w[15:10] = 6'($urandom);
            run_op(w, rnd128(), rnd128(), "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule